// File: doc/BRIEF.md
# SPI Master/Slave Controller

A byte-wide serial peripheral controller that is configured through one 8-bit control register and can act as either end of an SPI link. As master it derives the serial clock from the system clock at one of four rates, shifts a byte out on its data output while it captures the returning byte, and can own the slave-select line itself. As slave it follows an external serial clock and select. All three inputs are resynchronised inside the block before it looks for edges.

Software drives the block through a small register port. Address 0 holds the control register. A write to address 1 loads the transmit byte, and in master mode that write also starts the transfer; a read of address 1 returns the byte last received. Address 2 reports status. Clock polarity, clock phase and bit order can be changed between transfers. The slave-select pin is driven only when the master role, the select-output enable and the external mode-fault-disable input all agree. In every other case the pin is left to the surrounding pin logic.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register reads 0, status reads 0, and no pin output enable (`selOe`, `masterOe`, `misoOe`) is asserted.
- R2: The control register at address 0 reads back what was written. Its fields are bit 7 select-output enable, bit 6 enable, bit 5 LSB-first, bit 4 master, bit 3 CPOL, bit 2 CPHA, bits 1:0 rate. Status at address 2 holds busy in bit 0 and done in bit 1.
- R3: While the enable bit is 0, a data write starts nothing, `busy` stays 0 and `masterOe` stays 0.
- R4: In master mode with enable set, an accepted write to address 1 raises `busy` on the next cycle. `busy` stays high for 17·H cycles, where H = 2^rate system clocks. It falls together with the rise of `done`.
- R5: The serial clock rests at the CPOL level whenever no master transfer runs. During a transfer it toggles every H cycles, 16 times in all.
- R6: With CPHA=0, data is sampled on the first edge of each bit, and the first bit is on the output before the first edge. With CPHA=1, data changes on the first edge of each bit and is sampled on the second. The received byte is read at address 1.
- R7: With LSB-first=0 the byte leaves and arrives MSB first. With LSB-first=1 it leaves and arrives LSB first.
- R8: `selOe` is 1 exactly when master, select-output enable and `faultDisable` are all 1. While it is 1, `selOut` is low during a transfer and high otherwise.
- R9: Writes to either register are ignored while `busy` is 1.
- R10: In slave mode with enable set and the select input low, the block receives a byte on `mosiIn` and returns its loaded byte on `misoOut`. `done` is set once the eighth bit has been sampled.
- R11: Releasing the slave select before eight bits have been sampled abandons the byte. `done` stays 0, and the next selected byte is received from its first bit.
- R12: An accepted write to address 1 or to the control register clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 data, 2 status |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| faultDisable | input | 1 | Mode-fault disable; gates the select-pin drive |
| sclkIn | input | 1 | Serial clock in (slave) |
| selInN | input | 1 | Active-low select in (slave) |
| mosiIn | input | 1 | Serial data in (slave) |
| misoIn | input | 1 | Serial data in (master) |
| sclkOut | output | 1 | Serial clock out (master) |
| mosiOut | output | 1 | Serial data out (master) |
| misoOut | output | 1 | Serial data out (slave) |
| selOut | output | 1 | Select output level |
| selOe | output | 1 | Select output enable |
| masterOe | output | 1 | Enable for the clock and data outputs of the master |
| misoOe | output | 1 | Enable for `misoOut` while selected as slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer-complete flag |

## Verification
The assertions assume that no control or data write lands while the block is busy, other than writes it must discard. They also assume that the slave sees a serial clock whose half period spans at least four system clocks, so that the two-stage synchronisers and the edge detector can follow it. The stimulus keeps to these limits: master-to-slave loop transfers run only at the ÷8 and ÷16 rates, and the faster rates are checked on the master pins alone. All configuration changes are made between transfers, except for the deliberate discarded writes. The hand-driven slave sequence in the abort test holds every clock level for eight cycles.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  localparam int REG_W = 8;

  // field order is the software-visible bit layout, bit 7 first
  typedef struct packed {
    logic       ssoe;
    logic       en;
    logic       lsbFirst;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrlReg_t;

  // strobes from the control half to the shifter half
  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic fromMosi;
  } dpStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_HALF    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] ctrlWdata,
  input  logic             sclkIn,
  input  logic             mosiIn,
  input  logic             selInN,
  output ctrlReg_t         ctrlQ,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             sclkOut,
  output logic             mosiSync,
  output logic             slaveAct
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HALF_W = $clog2(MAX_HALF);

  logic [SYNC_STAGES-1:0] sclkSync, mosiSyncR, selSync;
  logic sclkS, selS, sclkPrev;
  logic mBusy, ph;
  logic [EDGE_W-1:0] edgeIdx;
  logic [HALF_W-1:0] halfCnt, halfMax;
  logic [BIT_W-1:0]  bitCnt;
  logic dataWr, ctrlWr, startM, loadOk, tick, lastTick, mEdge, lead, mSample, mShift;
  logic sEdge, sLead, sTrail, sSample, sShift, sLast;

  // input synchronisers for the slave side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync  <= '0;
      mosiSyncR <= '0;
      selSync   <= '1;
    end else begin
      sclkSync  <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      mosiSyncR <= {mosiSyncR[SYNC_STAGES-2:0], mosiIn};
      selSync   <= {selSync[SYNC_STAGES-2:0], selInN};
    end
  end

  always_comb begin
    sclkS    = sclkSync[SYNC_STAGES-1];
    selS     = selSync[SYNC_STAGES-1];
    mosiSync = mosiSyncR[SYNC_STAGES-1];
    slaveAct = ctrlQ.en && !ctrlQ.mstr && !selS;
    busy     = mBusy || slaveAct;
    dataWr   = regWe && (regAddr == ADDR_DATA);
    ctrlWr   = regWe && (regAddr == ADDR_CTRL) && !busy;
    startM   = dataWr && ctrlQ.en && ctrlQ.mstr && !mBusy;
    loadOk   = dataWr && ctrlQ.en && !busy;
    halfMax  = HALF_W'((1 << ctrlQ.rate) - 1);
    tick     = mBusy && (halfCnt == halfMax);
    lastTick = tick && (edgeIdx == EDGE_W'(EDGES));
    mEdge    = tick && !lastTick;
    lead     = !edgeIdx[0];
    mSample  = mEdge && (ctrlQ.cpha ? !lead : lead);
    mShift   = mEdge && (ctrlQ.cpha ? (lead && (edgeIdx != '0)) : !lead);
    sEdge    = slaveAct && (sclkS != sclkPrev);
    sLead    = sEdge && (sclkPrev == ctrlQ.cpol);
    sTrail   = sEdge && (sclkPrev != ctrlQ.cpol);
    sSample  = ctrlQ.cpha ? sTrail : sLead;
    sShift   = ctrlQ.cpha ? (sLead && (bitCnt != '0)) : sTrail;
    sLast    = sSample && (bitCnt == BIT_W'(DATA_W - 1));
    strobe   = '{load: loadOk, shift: mShift || sShift,
                 sample: mSample || sSample, fromMosi: !ctrlQ.mstr};
    sclkOut  = ctrlQ.cpol ^ (mBusy && ph);
  end

  // control register and master sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      mBusy   <= 1'b0;
      ph      <= 1'b0;
      edgeIdx <= '0;
      halfCnt <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= ctrlReg_t'(ctrlWdata);
      if (!ctrlQ.en) begin
        mBusy   <= 1'b0;
        ph      <= 1'b0;
        edgeIdx <= '0;
        halfCnt <= '0;
      end else if (startM) begin
        mBusy   <= 1'b1;
        ph      <= 1'b0;
        edgeIdx <= '0;
        halfCnt <= '0;
      end else if (mBusy) begin
        if (tick) begin
          halfCnt <= '0;
          edgeIdx <= edgeIdx + EDGE_W'(1);
          if (lastTick) mBusy <= 1'b0;
          else          ph    <= ~ph;
        end else begin
          halfCnt <= halfCnt + HALF_W'(1);
        end
      end
    end
  end

  // slave bit counter and completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      done     <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!slaveAct)   bitCnt <= '0;
      else if (sSample) bitCnt <= sLast ? '0 : bitCnt + BIT_W'(1);
      if (lastTick || sLast)  done <= 1'b1;
      else if (loadOk || ctrlWr) done <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_xcvr_dp.sv
module spi_xcvr_dp
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              misoIn,
  input  logic              mosiSync,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txSh, rxSh;
  logic inBit;

  always_comb begin
    inBit  = strobe.fromMosi ? mosiSync : misoIn;
    txBit  = lsbFirst ? txSh[0] : txSh[DATA_W-1];
    rxData = rxSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (strobe.load)       txSh <= wrData;
      else if (strobe.shift) txSh <= lsbFirst ? (txSh >> 1) : (txSh << 1);
      if (strobe.sample)
        rxSh <= lsbFirst ? {inBit, rxSh[DATA_W-1:1]} : {rxSh[DATA_W-2:0], inBit};
    end
  end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              faultDisable,
  input  logic              sclkIn,
  input  logic              selInN,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              sclkOut,
  output logic              mosiOut,
  output logic              misoOut,
  output logic              selOut,
  output logic              selOe,
  output logic              masterOe,
  output logic              misoOe,
  output logic              busy,
  output logic              done
);
  ctrlReg_t          ctrlQ;
  dpStrobe_t         strobe;
  logic              mosiSync, slaveAct, txBit;
  logic [DATA_W-1:0] rxData;

  spi_xcvr_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .ctrlWdata(regWdata[REG_W-1:0]), .sclkIn(sclkIn), .mosiIn(mosiIn),
    .selInN(selInN), .ctrlQ(ctrlQ), .strobe(strobe), .busy(busy), .done(done),
    .sclkOut(sclkOut), .mosiSync(mosiSync), .slaveAct(slaveAct)
  );

  spi_xcvr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lsbFirst(ctrlQ.lsbFirst),
    .wrData(regWdata), .misoIn(misoIn), .mosiSync(mosiSync),
    .txBit(txBit), .rxData(rxData)
  );

  always_comb begin
    mosiOut  = txBit;
    misoOut  = txBit;
    masterOe = ctrlQ.en && ctrlQ.mstr;
    misoOe   = slaveAct;
    selOe    = ctrlQ.mstr && ctrlQ.ssoe && faultDisable;
    selOut   = !(selOe && busy);
    case (regAddr)
      ADDR_CTRL: regRdata = DATA_W'(ctrlQ);
      ADDR_DATA: regRdata = rxData;
      ADDR_STAT: regRdata = DATA_W'({done, busy});
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk
  import spi_xcvr_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input ctrlReg_t ctrlQ,
  input logic     busy,
  input logic     done,
  input logic     sclkOut,
  input logic     selOut,
  input logic     selOe,
  input logic     masterOe,
  input logic     regWe
);
  assert_sel_low_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (selOe && busy) |-> !selOut);
  assert_sel_high_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> selOut);
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclkOut == ctrlQ.cpol));
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe) |=> $stable(ctrlQ));
  assert_off_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.en |-> (!busy && !masterOe));
  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.mstr && $rose(done)) |-> $fell(busy));
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .busy(busy), .done(done),
  .sclkOut(sclkOut), .selOut(selOut), .selOe(selOe), .masterOe(masterOe),
  .regWe(regWe)
);

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic dWe = 0, sWe = 0, fd = 0;
  logic [1:0] dAddr = 0, sAddr = 0;
  logic [7:0] dWdata = 0, sWdata = 0, dRd, sRd;
  logic benchDrive = 0, bSclk = 0, bMosi = 0, bSel = 1;
  logic dSclk, dMosi, dMiso, dSelOut, dSelOe, dMOe, dMisoOe, dBusy, dDone;
  logic sSclk, sMosi, sMiso, sSelOut, sSelOe, sMOe, sMisoOe, sBusy, sDone;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_xcvr u_dut (
    .clk(clk), .rstN(rstN), .regWe(dWe), .regAddr(dAddr), .regWdata(dWdata),
    .regRdata(dRd), .faultDisable(fd), .sclkIn(1'b0), .selInN(1'b1),
    .mosiIn(1'b0), .misoIn(sMiso), .sclkOut(dSclk), .mosiOut(dMosi),
    .misoOut(dMiso), .selOut(dSelOut), .selOe(dSelOe), .masterOe(dMOe),
    .misoOe(dMisoOe), .busy(dBusy), .done(dDone)
  );

  spi_xcvr u_slv (
    .clk(clk), .rstN(rstN), .regWe(sWe), .regAddr(sAddr), .regWdata(sWdata),
    .regRdata(sRd), .faultDisable(fd),
    .sclkIn(benchDrive ? bSclk : dSclk), .selInN(benchDrive ? bSel : dSelOut),
    .mosiIn(benchDrive ? bMosi : dMosi), .misoIn(1'b0), .sclkOut(sSclk),
    .mosiOut(sMosi), .misoOut(sMiso), .selOut(sSelOut), .selOe(sSelOe),
    .masterOe(sMOe), .misoOe(sMisoOe), .busy(sBusy), .done(sDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural model of the master-side pins
  int mEl = -1, edgeN = 0, capN = 0;
  logic [7:0] mcfg = 0, capMosi = 0;
  bit mb, capOn = 0;
  logic lastSclk = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mEl = -1; mcfg = 0; capOn = 0;
    end else begin
      mb = (mEl >= 0);
      if (mEl >= 0) begin
        mEl++;
        if (mEl >= 17 * (1 << mcfg[1:0])) mEl = -1;
      end
      if (dWe && dAddr == 2'd0 && !mb) mcfg = dWdata;
      else if (dWe && dAddr == 2'd1 && !mb && mcfg[6] && mcfg[4]) begin
        mEl = 0; edgeN = 0; capN = 0; lastSclk = mcfg[3]; capOn = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      int h, tg;
      logic eb, eo;
      h  = 1 << mcfg[1:0];
      eb = (mEl >= 0);
      tg = eb ? ((mEl / h) > 16 ? 16 : mEl / h) : 0;
      eo = mcfg[4] && mcfg[7] && fd;
      chk("R4 busy window", dBusy, eb);
      chk("R5 sclk level", dSclk, mcfg[3] ^ tg[0]);
      chk("R8 selOe", dSelOe, eo);
      chk("R8 selOut", dSelOut, !(eo && eb));
      if (capOn && dSclk != lastSclk) begin
        if (edgeN[0] == mcfg[2]) begin
          if (capN < 8) capMosi[capN[2:0]] = dMosi;
          capN++;
        end
        edgeN++;
        lastSclk = dSclk;
      end
      if (mEl < 0) capOn = 0;
    end
  end

  task automatic wrD(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); dAddr = a; dWdata = d; dWe = 1;
    @(negedge clk); dWe = 0;
  endtask

  task automatic wrS(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sAddr = a; sWdata = d; sWe = 1;
    @(negedge clk); sWe = 0;
  endtask

  task automatic rdD(input logic [1:0] a, output logic [7:0] d);
    dAddr = a; #1 d = dRd;
  endtask

  task automatic rdS(input logic [1:0] a, output logic [7:0] d);
    sAddr = a; #1 d = sRd;
  endtask

  task automatic cfg(input logic ssoe, input logic lsb, input logic mstr, input logic cpol,
                     input logic cpha, input logic [1:0] rate, input logic fdv);
    @(posedge clk); #1 fd = fdv;
    wrD(2'd0, {ssoe, 1'b1, lsb, mstr, cpol, cpha, rate});
    wrS(2'd0, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, rate});
  endtask

  task automatic waitIdle();
    int n = 0;
    while (dBusy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic xfer(input logic [7:0] mtx, input logic [7:0] stx,
                      input bit withSlave, input logic lsb);
    logic [7:0] rd, expSeq;
    if (withSlave) wrS(2'd1, stx);
    wrD(2'd1, mtx);
    chk("R12 done cleared by start", dDone, 1'b0);
    waitIdle();
    chk("R4 done after transfer", dDone, 1'b1);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) expSeq[i] = lsb ? mtx[i] : mtx[7-i];
    chk("R7 serial bit order", capMosi, expSeq);
    chk("R5 sclk edge count", edgeN, 16);
    if (withSlave) begin
      rdD(2'd1, rd);
      chk("R6 master received byte", rd, stx);
      rdS(2'd1, rd);
      chk("R10 slave received byte", rd, mtx);
      chk("R10 slave done", sDone, 1'b1);
    end
  endtask

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdD(2'd0, rd); chk("R1 ctrl after reset", rd, 8'h00);
    rdD(2'd2, rd); chk("R1 status after reset", rd, 8'h00);
    chk("R1 selOe", dSelOe, 1'b0);
    chk("R1 masterOe", dMOe, 1'b0);
    chk("R1 misoOe", sMisoOe, 1'b0);

    // R2 readback; enable bit clear so nothing runs
    wrD(2'd0, 8'b1011_1110);
    rdD(2'd0, rd); chk("R2 ctrl readback", rd, 8'hBE);

    // R3 disabled: data write starts nothing
    wrD(2'd1, 8'h5A);
    repeat (5) @(negedge clk);
    rdD(2'd2, rd); chk("R3 status while disabled", rd, 8'h00);
    chk("R3 masterOe while disabled", dMOe, 1'b0);

    // R5 R6 R7 R10: every clock mode with both bit orders, loop to the slave
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m, s;
      m = 8'h1D ^ 8'(k * 8'h27);
      s = 8'hB4 ^ 8'(k * 8'h53);
      cfg(1'b1, k[0], 1'b1, k[1], k[2], k[0] ? 2'd3 : 2'd2, 1'b1);
      rdD(2'd0, rd); chk("R2 ctrl fields", rd, {1'b1, 1'b1, k[0], 1'b1, k[1], k[2], k[0] ? 2'd3 : 2'd2});
      xfer(m, s, 1'b1, k[0]);
      rdD(2'd2, rd); chk("R2 status done bit", rd, 8'h02);
    end

    // R4 R5 fast rates, master pins only
    for (int r = 0; r < 2; r++) begin
      cfg(1'b0, r[0], 1'b1, 1'b1, r[0], 2'(r), 1'b0);
      xfer(8'hC6 + 8'(r), 8'h00, 1'b0, r[0]);
    end

    // R8 every combination of master, select enable and fault disable
    for (int c = 0; c < 8; c++) begin
      cfg(c[1], 1'b0, c[0], 1'b0, 1'b0, 2'd1, c[2]);
      if (c[0]) begin
        wrD(2'd1, 8'h5A);
        repeat (10) @(negedge clk);
        chk("R8 selOe mid transfer", dSelOe, c[0] & c[1] & c[2]);
        chk("R8 selOut mid transfer", dSelOut, !(c[0] & c[1] & c[2]));
        waitIdle();
        @(negedge clk);
        chk("R8 selOut idle", dSelOut, 1'b1);
      end else begin
        chk("R8 selOe slave mode", dSelOe, 1'b0);
      end
    end

    // R9 writes during busy are discarded
    cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1);
    wrS(2'd1, 8'h3C);
    wrD(2'd1, 8'hC3);
    repeat (20) @(negedge clk);
    wrD(2'd1, 8'h11);
    wrD(2'd0, 8'h00);
    waitIdle();
    repeat (6) @(negedge clk);
    rdS(2'd1, rd); chk("R9 slave got first byte", rd, 8'hC3);
    rdD(2'd0, rd); chk("R9 ctrl unchanged", rd, 8'b1101_0111);
    rdD(2'd1, rd); chk("R9 master got slave byte", rd, 8'h3C);

    // R12 control write clears done
    chk("R12 done before ctrl write", dDone, 1'b1);
    wrD(2'd0, 8'b1101_0111);
    chk("R12 done cleared by ctrl write", dDone, 1'b0);

    // R11 abort on early select release, then a clean byte
    cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1);
    wrS(2'd1, 8'h77);
    benchDrive = 1; bSel = 1; bSclk = 0;
    repeat (8) @(negedge clk);
    bSel = 0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      bMosi = b[0];
      repeat (8) @(negedge clk);
      bSclk = 1; repeat (8) @(negedge clk);
      bSclk = 0;
    end
    repeat (8) @(negedge clk);
    chk("R10 slave busy while selected", sBusy, 1'b1);
    bSel = 1;
    repeat (8) @(negedge clk);
    chk("R11 slave idle after release", sBusy, 1'b0);
    chk("R11 no done after abort", sDone, 1'b0);
    benchDrive = 0;
    repeat (4) @(negedge clk);
    xfer(8'hE1, 8'h2D, 1'b1, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule